// File: doc/BRIEF.md
# Hybrid Majority Voter with Standby Spares

This block sits behind a group of redundant compute modules and forms one trusted result from them. Of the `N_ACT + N_SPARE` physical modules, `N_ACT` fill voting slots at any one time, and the rest wait as standby spares. In every cycle the block selects the result of the module that fills each slot. It then forms a bitwise majority over the slots and drives that value out. While `in_valid` is high, it also compares every slot against the voted value.

A slot whose module disagrees with the vote loses that module. The module is flagged faulty for good, and the next unused spare takes its place on the following clock edge. When no spare is left, the flagged module stays in its slot and keeps voting, and a sticky degraded flag rises. With the default five slots, any two wrong slots are outvoted.

Top module: `hnv_spare_voter`

## Requirements
- R1: Bit b of `voted` is 1 exactly when at least `N_ACT/2+1` of the active slots (three of five by default) have bit b set; it is combinational from `mod_res` and `slot_map`.
- R2: One slot carrying a wrong value does not change `voted`.
- R3: Two slots carrying wrong values in the same cycle do not change `voted` when `N_ACT` is 5.
- R4: While `in_valid` is low, `slot_map` and `fault_mask` keep their values whatever the results.
- R5: When a slot disagrees with `voted` while `in_valid` is high and a spare remains, at the next clock edge that slot takes the lowest-indexed unused spare, and the `fault_mask` bit of the module it held is set. Spares are the module indices `N_ACT` to `N_ACT+N_SPARE-1`, used in ascending order. Field s of `slot_map` (bits `s*IDXW +: IDXW`) gives the module that fills slot s, and bit j of `fault_mask` flags module j.
- R6: When several slots disagree in one cycle, only the lowest-numbered one is handled at that edge, and the next one at the following edge.
- R7: Only the modules named in `slot_map` reach the vote, and a module flagged faulty never fills a slot again before reset. Its fault bit never clears.
- R8: `spares_out` rises once every spare is in use. When a disagreeing slot holds a healthy module and no spare remains, that module is flagged faulty but stays in its slot and keeps voting, and `degraded` goes high and stays high until reset.
- R9: Reset (`rst_n` low) maps slot i to module i, clears `fault_mask`, and drives `spares_out` and `degraded` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Results are valid and may be judged this cycle |
| mod_res | input | (N_ACT+N_SPARE)*WIDTH | Results of all physical modules; module j at bits j*WIDTH |
| voted | output | WIDTH | Bitwise majority over the active slots |
| slot_map | output | N_ACT*IDXW | Physical module index held by each slot |
| fault_mask | output | N_ACT+N_SPARE | One bit per module, set once it has been found faulty |
| spares_out | output | 1 | All spares are in service |
| degraded | output | 1 | A faulty module was kept in the vote for lack of a spare |

## Verification
Two events can land on the same edge. The first is several slots disagreeing together, where the design has to serialise the swaps. The second is the last spare running out while a further slot is still waiting for a swap. The bench corrupts two slots at once and holds those results over two edges, which takes the final spare. It then corrupts another healthy slot. The judgement is made on the slot map and fault mask after each edge, together with the vote, which must still mask the errors. The vote also has to show that the module kept in its slot after the spares ran out still takes part in it.

// File: rtl/hnv_pkg.sv
package hnv_pkg;
   typedef enum logic [1:0] {
      ACT_IDLE = 2'd0,
      ACT_SWAP = 2'd1,
      ACT_KEEP = 2'd2
   } hnv_action_e;

   function automatic int unsigned hnv_idx_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/hnv_slot_mux.sv
module hnv_slot_mux #(
   parameter int WIDTH = 8,
   parameter int N_ACT = 5,
   parameter int NMOD  = 7,
   parameter int IDXW  = 3
) (
   input  logic [NMOD*WIDTH-1:0]  mod_res,
   input  logic [N_ACT*IDXW-1:0]  slot_map,
   output logic [N_ACT*WIDTH-1:0] slot_res
);
   for (genvar s = 0; s < N_ACT; s++) begin : g_slot
      logic [IDXW-1:0]  sel;
      logic [WIDTH-1:0] val;
      assign sel = slot_map[s*IDXW +: IDXW];
      always_comb begin
         val = '0;
         for (int j = 0; j < NMOD; j++) begin
            if (sel == IDXW'(j)) val = mod_res[j*WIDTH +: WIDTH];
         end
      end
      assign slot_res[s*WIDTH +: WIDTH] = val;
   end
endmodule

// File: rtl/hnv_majority.sv
module hnv_majority #(
   parameter int WIDTH = 8,
   parameter int N_ACT = 5
) (
   input  logic [N_ACT*WIDTH-1:0] slot_res,
   output logic [WIDTH-1:0]       voted
);
   localparam int THRESH = N_ACT / 2 + 1;
   localparam int CW     = $clog2(N_ACT + 1);

   if (N_ACT == 3) begin : g_tri
      logic [WIDTH-1:0] a, b, c;
      assign a = slot_res[0 +: WIDTH];
      assign b = slot_res[WIDTH +: WIDTH];
      assign c = slot_res[2*WIDTH +: WIDTH];
      assign voted = (a & b) | (a & c) | (b & c);
   end else begin : g_count
      for (genvar bt = 0; bt < WIDTH; bt++) begin : g_bit
         logic [CW-1:0] ones;
         always_comb begin
            ones = '0;
            for (int s = 0; s < N_ACT; s++) ones = ones + CW'(slot_res[s*WIDTH + bt]);
         end
         assign voted[bt] = (ones >= CW'(THRESH));
      end
   end
endmodule

// File: rtl/hnv_replace_ctrl.sv
module hnv_replace_ctrl
   import hnv_pkg::*;
#(
   parameter int N_ACT   = 5,
   parameter int N_SPARE = 2,
   parameter int NMOD    = 7,
   parameter int IDXW    = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N_ACT-1:0]      cand,
   output logic [N_ACT*IDXW-1:0] slot_map,
   output logic [NMOD-1:0]       fault_mask,
   output logic                  spares_out,
   output logic                  degraded
);
   localparam int PTRW = $clog2(NMOD + 1);
   localparam int SELW = hnv_idx_w(N_ACT);

   logic [PTRW-1:0] next_spare;
   logic [SELW-1:0] pick;
   logic            any_cand;
   hnv_action_e     act;
   logic [IDXW-1:0] old_mod;

   always_comb begin
      pick = '0;
      for (int s = N_ACT - 1; s >= 0; s--) begin
         if (cand[s]) pick = SELW'(s);
      end
   end

   assign any_cand   = |cand;
   assign spares_out = (next_spare == PTRW'(NMOD));
   assign old_mod    = slot_map[pick*IDXW +: IDXW];

   always_comb begin
      if (!any_cand)       act = ACT_IDLE;
      else if (spares_out) act = ACT_KEEP;
      else                 act = ACT_SWAP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < N_ACT; s++) slot_map[s*IDXW +: IDXW] <= IDXW'(s);
         fault_mask <= '0;
         next_spare <= PTRW'(N_ACT);
         degraded   <= 1'b0;
      end else begin
         case (act)
            ACT_SWAP: begin
               fault_mask[old_mod]           <= 1'b1;
               slot_map[pick*IDXW +: IDXW]   <= next_spare[IDXW-1:0];
               next_spare                    <= next_spare + PTRW'(1);
            end
            ACT_KEEP: begin
               fault_mask[old_mod] <= 1'b1;
               degraded            <= 1'b1;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/hnv_spare_voter.sv
module hnv_spare_voter
   import hnv_pkg::*;
#(
   parameter int WIDTH   = 8,
   parameter int N_ACT   = 5,
   parameter int N_SPARE = 2,
   localparam int NMOD   = N_ACT + N_SPARE,
   localparam int IDXW   = hnv_idx_w(NMOD)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [NMOD*WIDTH-1:0] mod_res,
   output logic [WIDTH-1:0]      voted,
   output logic [N_ACT*IDXW-1:0] slot_map,
   output logic [NMOD-1:0]       fault_mask,
   output logic                  spares_out,
   output logic                  degraded
);
   if (N_ACT < 3 || (N_ACT % 2) == 0) begin : g_bad_nact
      $error("hnv_spare_voter: N_ACT must be odd and at least 3");
   end
   if (N_SPARE < 1) begin : g_bad_spare
      $error("hnv_spare_voter: N_SPARE must be at least 1");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("hnv_spare_voter: WIDTH must be at least 1");
   end

   logic [N_ACT*WIDTH-1:0] slot_res;
   logic [N_ACT-1:0]       cand;

   hnv_slot_mux #(.WIDTH(WIDTH), .N_ACT(N_ACT), .NMOD(NMOD), .IDXW(IDXW)) u_mux (
      .mod_res (mod_res),
      .slot_map(slot_map),
      .slot_res(slot_res)
   );

   hnv_majority #(.WIDTH(WIDTH), .N_ACT(N_ACT)) u_vote (
      .slot_res(slot_res),
      .voted   (voted)
   );

   for (genvar s = 0; s < N_ACT; s++) begin : g_dis
      logic [IDXW-1:0] held;
      assign held    = slot_map[s*IDXW +: IDXW];
      assign cand[s] = in_valid && (slot_res[s*WIDTH +: WIDTH] != voted) && !fault_mask[held];
   end

   hnv_replace_ctrl #(.N_ACT(N_ACT), .N_SPARE(N_SPARE), .NMOD(NMOD), .IDXW(IDXW)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cand      (cand),
      .slot_map  (slot_map),
      .fault_mask(fault_mask),
      .spares_out(spares_out),
      .degraded  (degraded)
   );
endmodule

// File: rtl/hnv_spare_voter_chk.sv
module hnv_spare_voter_chk #(
   parameter int N_ACT = 5,
   parameter int NMOD  = 7,
   parameter int IDXW  = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  in_valid,
   input logic [N_ACT*IDXW-1:0] slot_map,
   input logic [NMOD-1:0]       fault_mask,
   input logic                  spares_out,
   input logic                  degraded
);
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(fault_mask) && $stable(slot_map))); // R4
   AST_ONE_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(fault_mask ^ $past(fault_mask)) <= 1)); // R6
   AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((fault_mask & $past(fault_mask)) == $past(fault_mask))); // R7
   AST_DEGRADED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      degraded |=> degraded); // R8
   AST_EXHAUST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      spares_out |=> spares_out); // R8
   AST_DEGRADED_NEEDS_EXHAUST: assert property (@(posedge clk) disable iff (!rst_n)
      degraded |-> spares_out); // R8
endmodule

bind hnv_spare_voter hnv_spare_voter_chk #(.N_ACT(N_ACT), .NMOD(NMOD), .IDXW(IDXW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .slot_map  (slot_map),
   .fault_mask(fault_mask),
   .spares_out(spares_out),
   .degraded  (degraded)
);

// File: tb/tb_hnv_spare_voter.sv
module tb_hnv_spare_voter;
   localparam int WIDTH = 8;
   localparam int N_ACT = 5;
   localparam int NMOD  = 7;
   localparam int IDXW  = 3;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  in_valid = 1'b0;
   logic [WIDTH-1:0]      mods [NMOD];
   logic [NMOD*WIDTH-1:0] mod_res;
   logic [WIDTH-1:0]      voted;
   logic [N_ACT*IDXW-1:0] slot_map;
   logic [NMOD-1:0]       fault_mask;
   logic                  spares_out;
   logic                  degraded;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   always_comb begin
      for (int j = 0; j < NMOD; j++) mod_res[j*WIDTH +: WIDTH] = mods[j];
   end

   hnv_spare_voter #(.WIDTH(WIDTH), .N_ACT(N_ACT), .N_SPARE(2)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mod_res(mod_res),
      .voted(voted), .slot_map(slot_map), .fault_mask(fault_mask),
      .spares_out(spares_out), .degraded(degraded)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [WIDTH-1:0] maj5(input logic [WIDTH-1:0] a, b, c, d, e);
      logic [WIDTH-1:0] r;
      for (int bt = 0; bt < WIDTH; bt++)
         r[bt] = (int'(a[bt]) + int'(b[bt]) + int'(c[bt]) + int'(d[bt]) + int'(e[bt])) >= 3;
      return r;
   endfunction

   function automatic int slot_of(input int s);
      return int'(slot_map[s*IDXW +: IDXW]);
   endfunction

   task automatic set_all(input logic [WIDTH-1:0] v);
      for (int j = 0; j < NMOD; j++) mods[j] = v;
   endtask

   task automatic edge_step();
      @(posedge clk);
      #2;
   endtask

   task automatic do_reset();
      in_valid = 1'b0;
      set_all(8'h00);
      rst_n = 1'b0;
      edge_step();
      edge_step();
      rst_n = 1'b1;
      edge_step();
   endtask

   task automatic t_reset_state();
      do_reset();
      for (int s = 0; s < N_ACT; s++) chk("R9 identity map", slot_of(s), s);
      chk("R9 mask clear", fault_mask, 0);
      chk("R9 spares_out low", spares_out, 0);
      chk("R9 degraded low", degraded, 0);
   endtask

   task automatic t_vote_and_idle();
      do_reset();
      mods[0] = 8'hF0; mods[1] = 8'hCC; mods[2] = 8'hAA; mods[3] = 8'h00; mods[4] = 8'hFF;
      mods[5] = 8'h0F; mods[6] = 8'h0F;
      #1;
      chk("R1 mixed vote", voted, maj5(8'hF0, 8'hCC, 8'hAA, 8'h00, 8'hFF));
      mods[3] = 8'h81; mods[4] = 8'h18;
      #1;
      chk("R1 second vote", voted, maj5(8'hF0, 8'hCC, 8'hAA, 8'h81, 8'h18));
      edge_step();
      edge_step();
      chk("R4 mask unchanged without valid", fault_mask, 0);
      for (int s = 0; s < N_ACT; s++) chk("R4 map unchanged without valid", slot_of(s), s);
   endtask

   task automatic t_single_error();
      do_reset();
      set_all(8'h3C);
      mods[2] = 8'hFF;
      in_valid = 1'b1;
      #1;
      chk("R2 single error masked", voted, 8'h3C);
      edge_step();
      chk("R5 slot2 takes spare 5", slot_of(2), 5);
      chk("R5 module2 flagged", fault_mask, 7'b0000100);
      chk("R8 one spare left", spares_out, 0);
      mods[6] = 8'h00;
      #1;
      chk("R7 standby spare kept out of vote", voted, 8'h3C);
      edge_step();
      chk("R7 faulty module stays out", slot_of(2), 5);
      chk("R7 no further change", fault_mask, 7'b0000100);
      in_valid = 1'b0;
   endtask

   task automatic t_double_then_exhaust();
      do_reset();
      set_all(8'h55);
      mods[1] = 8'hAA; mods[3] = 8'hAA;
      in_valid = 1'b1;
      #1;
      chk("R3 two errors masked", voted, 8'h55);
      edge_step();
      chk("R6 lowest slot first", slot_of(1), 5);
      chk("R6 slot3 waits", slot_of(3), 3);
      chk("R6 one flag per edge", fault_mask, 7'b0000010);
      edge_step();
      chk("R6 slot3 next edge", slot_of(3), 6);
      chk("R6 second flag", fault_mask, 7'b0001010);
      chk("R8 spares exhausted", spares_out, 1);
      chk("R8 not yet degraded", degraded, 0);
      mods[0] = 8'h0F;
      #1;
      chk("R2 vote after swaps", voted, 8'h55);
      edge_step();
      chk("R8 module0 kept in slot", slot_of(0), 0);
      chk("R8 module0 flagged", fault_mask, 7'b0001011);
      chk("R8 degraded raised", degraded, 1);
      edge_step();
      chk("R8 degraded sticky", degraded, 1);
      chk("R8 mask steady", fault_mask, 7'b0001011);
      in_valid = 1'b0;
      mods[0] = 8'hFF; mods[2] = 8'hFF; mods[4] = 8'hFF;
      #1;
      chk("R8 kept module still votes", voted, 8'hFF);
      do_reset();
      chk("R9 degraded cleared", degraded, 0);
      chk("R9 map restored", slot_of(1), 1);
   endtask

   initial begin
      for (int j = 0; j < NMOD; j++) mods[j] = '0;
      t_reset_state();
      t_vote_and_idle();
      t_single_error();
      t_double_then_exhaust();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule